// File: doc/BRIEF.md
# Random-Order Pixel Dissolve Mask Controller

This block dissolves an image pixel by pixel in a pseudo-random order. It does not change the image itself. It keeps a one-bit-per-pixel mask beside the framebuffer and sets one mask bit at a time. The order of the addresses comes from a maximal-length Fibonacci shift register. The display pipeline reads the mask with the same address it uses for the framebuffer. For each pixel the block then passes either the palette colour or a fixed fade colour to the output.

The effect waits a set number of frames before it starts, counted from a pulse at the start of vertical blanking. After that it gives one write slot every `STEP_GAP + 1` clocks. The shift register cannot produce zero, so the first slot writes address 0. Values beyond the pixel count use up their slot and write nothing. When every pixel is covered, `done` rises. A clear input empties the mask and restarts the whole sequence, which brings the image back.

Top module: `fizzle_mask_ctrl`

## Requirements
- R1: While `rst` is high, and until the fade begins, `wr_strobe` is 0 and `done` is 0. While `rst` is high, `pix_out` is 0. After reset the mask is all zero, so every read returns the palette colour.
- R2: No mask write happens until `FRAME_WAIT` pulses of `blank_start` have been seen since reset or clear. Pulses after that count are ignored and do not change the write timing.
- R3: Call the clock edge that samples the `FRAME_WAIT`-th pulse edge E. The first write slot falls in the cycle that follows edge E+`STEP_GAP`. All later slots follow at a period of `STEP_GAP + 1` clocks, so any two writes are a whole number of periods apart.
- R4: The first write after the fade begins always targets address 0.
- R5: Every write address is below `IMG_W*IMG_H`. Over a full fade, each address from 0 to `IMG_W*IMG_H - 1` is written exactly once.
- R6: `done` goes to 1 in the cycle after the last pixel's write, which is write number `IMG_W*IMG_H`. After that, `done` stays at 1 and no further write occurs until clear.
- R7: A read address given in cycle t, together with the palette colour given in cycle t+1, produces `pix_out` after the edge that ends cycle t+1. `pix_out` is `FADE_COLOR` if that mask bit is set and `palette_in` otherwise. A read address at or beyond the pixel count always returns the palette colour.
- R8: `clear` empties the mask, drops `done`, and restarts the frame wait. The sequence that follows starts again with address 0.
- R9: When `clear` is high in the same cycle as a due write slot, no write strobe is issued and that address is left unset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Empties the mask and restarts the dissolve |
| blank_start | input | 1 | One-cycle pulse at the start of vertical blanking |
| rd_addr | input | ADDR_W | Pixel address being displayed, shared with the framebuffer |
| palette_in | input | COLOR_W | Palette colour of the pixel, one cycle after `rd_addr` |
| pix_out | output | COLOR_W | Selected colour: fade colour or palette colour |
| wr_strobe | output | 1 | A mask bit is being set this cycle |
| wr_addr | output | ADDR_W | Address of the mask bit being set |
| done | output | 1 | Every pixel of the mask has been set |

## Verification
The two functions that can fall in the same cycle are a due write slot and a `clear` request. The bench provokes this by watching for a live `wr_strobe` and raising `clear` in that same cycle. It then judges three things: the strobe must drop at once, `done` must be low afterwards, and a read of the address that was about to be written must return the palette colour. A second overlap is a stray `blank_start` pulse during the fade. The bench scatters such pulses through the fade and then checks that every pair of writes is still a whole number of slot periods apart.

// File: rtl/fizzle_pkg.sv
package fizzle_pkg;

  // Feedback tap set for a maximal-length sequence of width w (3..16).
  function automatic logic [31:0] fz_taps(input int w);
    case (w)
      3:  fz_taps = 32'h0006;
      4:  fz_taps = 32'h000C;
      5:  fz_taps = 32'h0014;
      6:  fz_taps = 32'h0030;
      7:  fz_taps = 32'h0060;
      8:  fz_taps = 32'h00B8;
      9:  fz_taps = 32'h0110;
      10: fz_taps = 32'h0240;
      11: fz_taps = 32'h0500;
      12: fz_taps = 32'h0829;
      13: fz_taps = 32'h100D;
      14: fz_taps = 32'h2015;
      15: fz_taps = 32'h6000;
      default: fz_taps = 32'hD008;
    endcase
  endfunction

  // One shift: feedback parity enters at bit 0.
  function automatic logic [31:0] fz_step(input logic [31:0] s,
                                          input logic [31:0] taps,
                                          input int w);
    logic [31:0] lim;
    lim = (32'h1 << w) - 32'h1;
    fz_step = ((s << 1) | {31'b0, ^(s & taps)}) & lim;
  endfunction

  // Address lies inside the image.
  function automatic logic fz_in_image(input logic [31:0] a, input int pixels);
    fz_in_image = (a < 32'(pixels));
  endfunction

endpackage

// File: rtl/fizzle_lfsr.sv
module fizzle_lfsr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         advance,
  output logic [W-1:0] state
);
  import fizzle_pkg::*;

  localparam logic [31:0] TAPS = fz_taps(W);

  logic [31:0] nxt;
  always_comb nxt = fz_step(32'(state), TAPS, W);

  always_ff @(posedge clk) begin
    if (rst || restart) state <= W'(1);
    else if (advance)   state <= nxt[W-1:0];
  end
endmodule

// File: rtl/fizzle_pacer.sv
module fizzle_pacer #(
  parameter int FRAME_WAIT = 600,
  parameter int STEP_GAP   = 3200
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic blank_start,
  input  logic halt,
  output logic fade_on,
  output logic step_due
);
  localparam int FW = $clog2(FRAME_WAIT + 1);
  localparam int GW = $clog2(STEP_GAP + 1);

  logic [FW-1:0] frame_cnt;
  logic [GW-1:0] gap_cnt;

  always_comb fade_on  = (frame_cnt == FW'(FRAME_WAIT));
  always_comb step_due = fade_on && !halt && (gap_cnt == GW'(STEP_GAP));

  always_ff @(posedge clk) begin
    if (rst || clear)
      frame_cnt <= '0;
    else if (blank_start && !fade_on)
      frame_cnt <= frame_cnt + FW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clear)
      gap_cnt <= '0;
    else if (fade_on && !halt)
      gap_cnt <= (gap_cnt == GW'(STEP_GAP)) ? '0 : gap_cnt + GW'(1);
  end
endmodule

// File: rtl/fizzle_mask_store.sv
module fizzle_mask_store #(
  parameter int              PIXELS     = 1200,
  parameter int              ADDR_W     = 11,
  parameter int              COLOR_W    = 12,
  parameter logic [COLOR_W-1:0] FADE_COLOR = 12'hA00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               we,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [COLOR_W-1:0] palette_in,
  output logic [COLOR_W-1:0] pix_out
);
  import fizzle_pkg::*;

  logic [PIXELS-1:0] bits;
  logic              hit_q;
  logic              rd_ok;

  always_comb rd_ok = fz_in_image(32'(rd_addr), PIXELS);

  always_ff @(posedge clk) begin
    if (rst || clear)
      bits <= '0;
    else if (we)
      bits[waddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      pix_out <= '0;
    end else begin
      hit_q   <= rd_ok ? bits[rd_addr] : 1'b0;
      pix_out <= hit_q ? FADE_COLOR : palette_in;
    end
  end
endmodule

// File: rtl/fizzle_mask_ctrl.sv
module fizzle_mask_ctrl #(
  parameter int                 IMG_W      = 40,
  parameter int                 IMG_H      = 30,
  parameter int                 FRAME_WAIT = 600,
  parameter int                 STEP_GAP   = 3200,
  parameter int                 COLOR_W    = 12,
  parameter logic [COLOR_W-1:0] FADE_COLOR = 12'hA00,
  localparam int                PIXELS     = IMG_W * IMG_H,
  localparam int                ADDR_W     = $clog2(PIXELS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               blank_start,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [COLOR_W-1:0] palette_in,
  output logic [COLOR_W-1:0] pix_out,
  output logic               wr_strobe,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic               done
);
  import fizzle_pkg::*;

  localparam int CW = $clog2(PIXELS + 1);

  logic              fade_on;
  logic              step_due;
  logic              zero_seen;
  logic              seq_ok;
  logic              advance;
  logic [ADDR_W-1:0] seq;
  logic [CW-1:0]     wr_count;

  fizzle_pacer #(
    .FRAME_WAIT(FRAME_WAIT),
    .STEP_GAP  (STEP_GAP)
  ) u_pacer (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .blank_start(blank_start),
    .halt       (done),
    .fade_on    (fade_on),
    .step_due   (step_due)
  );

  fizzle_lfsr #(.W(ADDR_W)) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .restart(clear),
    .advance(advance),
    .state  (seq)
  );

  // Slot use: address 0 first, then the sequence, skipping values past the image.
  always_comb begin
    seq_ok    = fz_in_image(32'(seq), PIXELS);
    advance   = step_due && !clear && zero_seen;
    wr_strobe = step_due && !clear && (!zero_seen || seq_ok);
    wr_addr   = zero_seen ? seq : '0;
    done      = (wr_count == CW'(PIXELS));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      zero_seen <= 1'b0;
      wr_count  <= '0;
    end else begin
      if (step_due) zero_seen <= 1'b1;
      if (wr_strobe) wr_count <= wr_count + CW'(1);
    end
  end

  fizzle_mask_store #(
    .PIXELS    (PIXELS),
    .ADDR_W    (ADDR_W),
    .COLOR_W   (COLOR_W),
    .FADE_COLOR(FADE_COLOR)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .we        (wr_strobe),
    .waddr     (wr_addr),
    .rd_addr   (rd_addr),
    .palette_in(palette_in),
    .pix_out   (pix_out)
  );
endmodule

// File: rtl/fizzle_mask_ctrl_chk.sv
module fizzle_mask_ctrl_chk #(
  parameter int PIXELS = 1200,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              clear,
  input logic              wr_strobe,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done,
  input logic              fade_on,
  input logic              zero_seen
);
  p_quiet_before_wait_r2: assert property (@(posedge clk) disable iff (rst)
    !fade_on |-> !wr_strobe);

  p_slot_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !wr_strobe);

  p_zero_first_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_strobe && !zero_seen) |-> (wr_addr == '0));

  p_addr_in_range_r5: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> (32'(wr_addr) < 32'(PIXELS)));

  p_silent_when_done_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_strobe);

  p_done_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !clear) |=> done);

  p_clear_drops_done_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> !done);

  p_clear_blocks_write_r9: assert property (@(posedge clk) disable iff (rst)
    clear |-> !wr_strobe);
endmodule

bind fizzle_mask_ctrl fizzle_mask_ctrl_chk #(
  .PIXELS(PIXELS),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clear    (clear),
  .wr_strobe(wr_strobe),
  .wr_addr  (wr_addr),
  .done     (done),
  .fade_on  (fade_on),
  .zero_seen(zero_seen)
);

// File: tb/fizzle_mask_ctrl_test.sv
module fizzle_mask_ctrl_test;
  localparam int   TW   = 40;
  localparam int   TH   = 30;
  localparam int   TP   = TW * TH;
  localparam int   AW   = $clog2(TP);
  localparam int   WAIT = 4;
  localparam int   GAP  = 5;
  localparam logic [11:0] FADE = 12'hA00;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clear = 1'b0;
  logic          blank_start = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [11:0]   palette_in = '0;
  logic [11:0]   pix_out;
  logic          wr_strobe;
  logic [AW-1:0] wr_addr;
  logic          done;

  fizzle_mask_ctrl #(
    .IMG_W(TW), .IMG_H(TH), .FRAME_WAIT(WAIT), .STEP_GAP(GAP),
    .COLOR_W(12), .FADE_COLOR(FADE)
  ) uut (
    .clk(clk), .rst(rst), .clear(clear), .blank_start(blank_start),
    .rd_addr(rd_addr), .palette_in(palette_in), .pix_out(pix_out),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .done(done)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int total  = 0;
  int last_cyc = -1;
  int gap_bad = 0;
  int range_bad = 0;
  int hits [TP];
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Write monitor, sampled well after the falling edge.
  always @(negedge clk) begin
    #3;
    if (!rst && wr_strobe) begin
      total++;
      if (32'(wr_addr) >= TP) range_bad++;
      else hits[wr_addr]++;
      if (last_cyc >= 0 && ((cyc - last_cyc) % (GAP + 1)) != 0) gap_bad++;
      last_cyc = cyc;
    end
  end

  function automatic logic [11:0] want_pix(input bit masked, input logic [11:0] pal);
    return masked ? FADE : pal;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic new_epoch();
    for (int i = 0; i < TP; i++) hits[i] = 0;
    total = 0;
    last_cyc = -1;
  endtask

  task automatic pulse_blank();
    blank_start = 1'b1;
    @(negedge clk);
    blank_start = 1'b0;
  endtask

  task automatic read_chk(input int a, input bit masked, input string tag);
    logic [11:0] pal;
    pal = 12'($urandom);
    rd_addr = AW'(a);
    @(negedge clk);
    palette_in = pal;
    @(negedge clk);
    @(negedge clk);
    chk(pix_out == want_pix(masked, pal), tag, int'(pix_out), int'(want_pix(masked, pal)));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    summary();
  end

  initial begin
    int seen;
    int a;
    int stale;
    int bad_once;
    int addr_cut;
    void'($urandom(32'h1F2E3D4C));
    new_epoch();

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pix_out == 12'h000, "R1 pix_out in reset", int'(pix_out), 0);
    chk(!wr_strobe && !done, "R1 strobe/done in reset", int'({wr_strobe, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) read_chk($urandom_range(TP - 1), 1'b0, "R1 empty mask read");

    // R2: fewer than WAIT pulses gives no writes
    for (int k = 0; k < WAIT - 1; k++) begin
      pulse_blank();
      repeat (2) @(negedge clk);
    end
    repeat (4 * (GAP + 1)) @(negedge clk);
    chk(total == 0, "R2 no write before wait", total, 0);
    chk(!done, "R1 done low before fade", int'(done), 0);

    // R3/R4: first slot timing and address
    pulse_blank();
    repeat (GAP - 1) @(negedge clk);
    chk(!wr_strobe, "R3 no strobe before first slot", int'(wr_strobe), 0);
    @(negedge clk);
    chk(wr_strobe, "R3 strobe at first slot", int'(wr_strobe), 1);
    chk(wr_addr == '0, "R4 first address zero", int'(wr_addr), 0);

    // Partial fade, then reads of already written pixels (R7)
    while (total < 60) @(negedge clk);
    seen = 0;
    a = $urandom_range(TP - 1);
    for (int k = 0; k < TP && seen < 4; k++) begin
      if (hits[(a + k) % TP] > 0) begin
        read_chk((a + k) % TP, 1'b1, "R7 set pixel shows fade");
        seen++;
      end
    end
    read_chk(0, 1'b1, "R7 address zero faded");

    // R9: clear lands on a live write slot
    @(negedge clk);
    while (!wr_strobe) @(negedge clk);
    addr_cut = int'(wr_addr);
    clear = 1'b1;
    new_epoch();
    #1;
    chk(!wr_strobe, "R9 clear suppresses strobe", int'(wr_strobe), 0);
    @(negedge clk);
    clear = 1'b0;
    chk(!done, "R8 done low after clear", int'(done), 0);
    read_chk(addr_cut, 1'b0, "R9 colliding address left unset");
    read_chk(0, 1'b0, "R8 mask emptied by clear");

    // R8: wait restarts after clear
    for (int k = 0; k < WAIT - 1; k++) begin
      pulse_blank();
      @(negedge clk);
    end
    repeat (3 * (GAP + 1)) @(negedge clk);
    chk(total == 0, "R8 wait restarted", total, 0);
    pulse_blank();
    repeat (GAP) @(negedge clk);
    chk(wr_strobe && wr_addr == '0, "R8 restart begins at zero", int'(wr_addr), 0);

    // Full fade with stray blanking pulses (R2 saturation)
    stale = 0;
    while (!done && stale < 60000) begin
      blank_start = ($urandom_range(199) == 0);
      @(negedge clk);
      stale++;
    end
    blank_start = 1'b0;
    chk(done, "R6 done raised", int'(done), 1);
    chk(total == TP, "R6 write count at done", total, TP);
    bad_once = 0;
    for (int i = 0; i < TP; i++) if (hits[i] != 1) bad_once++;
    chk(bad_once == 0, "R5 each address written once", bad_once, 0);
    chk(range_bad == 0, "R5 no out-of-range address", range_bad, 0);
    chk(gap_bad == 0, "R3 slot period kept", gap_bad, 0);

    // R6: silence after done
    repeat (5 * (GAP + 1)) @(negedge clk);
    chk(total == TP, "R6 no write after done", total, TP);
    chk(done, "R6 done holds", int'(done), 1);

    // R7: full mask reads
    for (int k = 0; k < 4; k++) read_chk($urandom_range(TP - 1), 1'b1, "R7 faded pixel");
    read_chk(TP, 1'b0, "R7 address past image uses palette");
    read_chk((1 << AW) - 1, 1'b0, "R7 top address uses palette");

    summary();
  end
endmodule